// File: doc/BRIEF.md
# DMA Channel Service Arbiter with Single-Level Preemption

This block decides which of a set of DMA channels is serviced next. Each channel raises a one-cycle request pulse. The arbiter latches the request and holds it until that channel has been granted and has completed one inner-loop iteration. The transfer engine beside the arbiter runs the granted channel. It reports the end of each iteration with a one-cycle `iter_done` strobe, and the arbiter then consumes the request.

A mode pin selects between two schemes. In fixed-priority mode, each channel carries a priority value and the largest value wins. In round-robin mode, priority values are ignored and the grant rotates through the channel indices. In fixed-priority mode only, a running channel whose preempt-enable bit is set can be suspended by a pending channel of strictly higher priority. The suspended channel keeps its active flag set. The preempting channel runs one iteration, and then the suspended channel resumes. Only one level of suspension exists.

All pins are plain control and status signals. There is no data stream and no valid/ready handshake. A grant is held until the engine reports `iter_done`, so back-pressure is implicit in that strobe.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, `active` is all zeros, no request is pending, and the round-robin pointer points at channel N_CH-1.
- R2: In fixed mode (`mode_rr`=0), when nothing runs and at least one channel is pending, the channel with the largest priority value is granted at the next clock edge. On a tie, the lowest index wins. A request pulse sampled at an edge already takes part in the arbitration at that edge.
- R3: In round-robin mode (`mode_rr`=1), the search starts at the index after the last granted channel and wraps from N_CH-1 to 0. Priority values play no part.
- R4: A request stays pending until its channel's iteration completes. A new request pulse for the running channel in the same cycle as its `iter_done` re-arms that channel.
- R5: Each grant covers one iteration. On `iter_done` with no suspended channel, `grant_valid` drops at the next edge, and arbitration resumes at the edge after that.
- R6: In fixed mode, a running channel is preempted at the next edge when all of the following hold: its preempt-enable bit is 1, no channel is suspended, `iter_done` is low, and a pending channel has a strictly higher priority. The grant moves to the best pending channel, and both channels show as active.
- R7: A running channel whose preempt-enable bit is 0 is never preempted. A pending channel of equal priority never preempts.
- R8: In round-robin mode, no preemption occurs. The grant is held until `iter_done`.
- R9: While a channel is suspended, the preempting channel cannot itself be preempted, whatever priority is pending.
- R10: `iter_done` from the preempting channel returns the grant to the suspended channel at the next edge. The suspended channel's active flag stays set throughout.
- R11: `iter_done` while nothing is granted has no effect.
- R12: `active` holds the one-hot bit of the granted channel, OR the bit of the suspended channel. Two set bits therefore mean that a preemption is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rr | input | 1 | 0 = fixed priority, 1 = round-robin |
| req | input | N_CH | One-cycle request pulses, one per channel |
| prio | input | N_CH*PRIO_W | Priority of channel i in bits [i*PRIO_W +: PRIO_W]; larger wins |
| preempt_en | input | N_CH | Channel i may be suspended when bit i is 1 |
| iter_done | input | 1 | Granted channel finished one iteration |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | $clog2(N_CH) | Index of the granted channel |
| active | output | N_CH | Running channel plus any suspended channel |

## Verification
The directed scenarios target four groups of cases.

Equal priorities must go to the lowest index; a design that compared with >= would grant the higher index. Round-robin must wrap past the last index; a design that restarted at zero would grant channel 1 before channel 6.

Preemption must require a strictly higher priority and a set enable bit on the running channel; a design that checked the wrong channel's enable bit would switch grants when it should not. A third request arriving during a suspension must wait; a nested-preemption bug would move the grant a second time. After a resume, a still-pending higher channel must preempt again; a design that lost the suspended flag would show only one active bit, or would never return to the suspended channel.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_FIXED = 1'b0,
    ARB_ROUND = 1'b1
  } arb_mode_e;

  function automatic int unsigned ch_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/arb_pend_reg.sv
module arb_pend_reg #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] set_vec,
  input  logic [N_CH-1:0] clr_vec,
  output logic [N_CH-1:0] pend_q
);
  for (genvar i = 0; i < N_CH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (set_vec[i]) pend_q[i] <= 1'b1;   // a fresh pulse wins over a clear
      else if (clr_vec[i]) pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned CH_W  = arb_pkg::ch_bits(N_CH)
) (
  input  logic [N_CH-1:0]        cand,
  input  logic [N_CH*PRIO_W-1:0] prio,
  output logic                   hit,
  output logic [CH_W-1:0]        idx,
  output logic [PRIO_W-1:0]      best
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < int'(N_CH); i++) begin
      // strict compare keeps the lowest index on a tie
      if (cand[i] && (!hit || prio[i*PRIO_W +: PRIO_W] > best)) begin
        hit  = 1'b1;
        idx  = CH_W'(i);
        best = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int unsigned N_CH  = 8,
  localparam int unsigned CH_W = arb_pkg::ch_bits(N_CH)
) (
  input  logic [N_CH-1:0] cand,
  input  logic [CH_W-1:0] last,
  output logic            hit,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 1; k <= int'(N_CH); k++) begin
      int j;
      j = int'(last) + k;
      if (j >= int'(N_CH)) j = j - int'(N_CH);
      if (!hit && cand[j]) begin
        hit = 1'b1;
        idx = CH_W'(j);
      end
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned CH_W  = arb_pkg::ch_bits(N_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_rr,
  input  logic [N_CH-1:0]        req,
  input  logic [N_CH*PRIO_W-1:0] prio,
  input  logic [N_CH-1:0]        preempt_en,
  input  logic                   iter_done,
  output logic                   grant_valid,
  output logic [CH_W-1:0]        grant_ch,
  output logic [N_CH-1:0]        active
);
  import arb_pkg::*;

  logic            running_q, susp_q;
  logic [CH_W-1:0] run_q, susp_ch_q, last_q;
  logic [N_CH-1:0] pend_q, clr_vec, cand, act_vec;
  logic            f_hit, r_hit, pick_hit, done_ev, do_preempt;
  logic [CH_W-1:0] f_idx, r_idx, pick_idx;
  logic [PRIO_W-1:0] f_best, run_prio;
  arb_mode_e       mode;

  assign mode = arb_mode_e'(mode_rr);

  always_comb begin
    act_vec = '0;
    if (running_q) act_vec[run_q]     = 1'b1;
    if (susp_q)    act_vec[susp_ch_q] = 1'b1;
  end

  assign done_ev = running_q && iter_done;

  always_comb begin
    clr_vec = '0;
    if (done_ev) clr_vec[run_q] = 1'b1;
  end

  arb_pend_reg #(.N_CH(N_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(req), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  // running and suspended channels never compete against themselves
  assign cand = (pend_q | req) & ~act_vec;

  arb_fixed_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_fixed (
    .cand(cand), .prio(prio), .hit(f_hit), .idx(f_idx), .best(f_best)
  );

  arb_rr_pick #(.N_CH(N_CH)) u_rr (
    .cand(cand), .last(last_q), .hit(r_hit), .idx(r_idx)
  );

  assign pick_hit = (mode == ARB_ROUND) ? r_hit : f_hit;
  assign pick_idx = (mode == ARB_ROUND) ? r_idx : f_idx;
  assign run_prio = prio[run_q*PRIO_W +: PRIO_W];

  assign do_preempt = running_q && !susp_q && !iter_done && (mode == ARB_FIXED)
                   && preempt_en[run_q] && f_hit && (f_best > run_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      susp_q    <= 1'b0;
      run_q     <= '0;
      susp_ch_q <= '0;
      last_q    <= CH_W'(N_CH - 1);
    end else if (done_ev) begin
      if (susp_q) begin
        run_q  <= susp_ch_q;
        susp_q <= 1'b0;
      end else begin
        running_q <= 1'b0;
      end
    end else if (do_preempt) begin
      susp_q    <= 1'b1;
      susp_ch_q <= run_q;
      run_q     <= f_idx;
      last_q    <= f_idx;
    end else if (!running_q && pick_hit) begin
      running_q <= 1'b1;
      run_q     <= pick_idx;
      last_q    <= pick_idx;
    end
  end

  assign grant_valid = running_q;
  assign grant_ch    = run_q;
  assign active      = act_vec;
endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned CH_W  = arb_pkg::ch_bits(N_CH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_rr,
  input logic [N_CH-1:0]        req,
  input logic [N_CH*PRIO_W-1:0] prio,
  input logic [N_CH-1:0]        preempt_en,
  input logic                   iter_done,
  input logic                   grant_valid,
  input logic [CH_W-1:0]        grant_ch,
  input logic [N_CH-1:0]        active
);
  logic [N_CH-1:0]   gvec, other;
  logic [PRIO_W-1:0] other_prio, g_prio;
  logic              two, one, prev_one, prev_pe, prev_rr;

  always_comb begin
    gvec = '0;
    if (grant_valid) gvec[grant_ch] = 1'b1;
    other = active & ~gvec;
    other_prio = '0;
    for (int i = 0; i < int'(N_CH); i++)
      if (other[i]) other_prio = prio[i*PRIO_W +: PRIO_W];
    g_prio = prio[grant_ch*PRIO_W +: PRIO_W];
  end

  assign two = ($countones(active) == 2);
  assign one = ($countones(active) == 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_one <= 1'b0;
      prev_pe  <= 1'b0;
      prev_rr  <= 1'b0;
    end else begin
      prev_one <= one && !iter_done;
      prev_pe  <= preempt_en[grant_ch];
      prev_rr  <= mode_rr;
    end
  end

  p_active_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(active) <= 2);
  p_grant_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> active[grant_ch]);
  p_idle_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (active == '0));
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && iter_done && one) |=> !grant_valid);
  p_rr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !iter_done && mode_rr) |=> (grant_valid && grant_ch == $past(grant_ch)));
  p_single_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (two && !iter_done) |=> (grant_ch == $past(grant_ch) && active == $past(active)));
  p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (two && iter_done) |=> (grant_valid && active == $past(other)));
  p_preempt_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (two && $stable(prio)) |-> (g_prio > other_prio));
  p_preempt_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (two && prev_one) |-> (prev_pe && !prev_rr));
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/tb_dma_chan_arbiter.sv
module tb_dma_chan_arbiter;
  localparam int N  = 8;
  localparam int PW = 4;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_rr = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [N-1:0]  preempt_en = '0;
  logic          iter_done = 1'b0;
  logic          grant_valid;
  logic [CW-1:0] grant_ch;
  logic [N-1:0]  active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  dma_chan_arbiter #(.N_CH(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_rr(mode_rr), .req(req), .prio(prio),
    .preempt_en(preempt_en), .iter_done(iter_done), .grant_valid(grant_valid),
    .grant_ch(grant_ch), .active(active)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      finish_run();
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic expect_state(string tag, logic v, int ch, logic [N-1:0] act);
    checks++;
    if (grant_valid !== v || active !== act || (v && grant_ch !== CW'(ch))) begin
      errors++;
      $display("FAIL %s: actual valid=%0b ch=%0d active=%b expected valid=%0b ch=%0d active=%b",
               tag, grant_valid, grant_ch, active, v, ch, act);
    end
  endtask

  function automatic logic [N-1:0] bit_of(int ch);
    return N'(1) << ch;
  endfunction

  task automatic set_prio(int ch, int val);
    prio[ch*PW +: PW] = PW'(val);
  endtask

  task automatic pulse_req(logic [N-1:0] m);
    req = m; step(); req = '0;
  endtask

  task automatic pulse_done();
    iter_done = 1'b1; step(); iter_done = 1'b0;
  endtask

  task automatic do_reset(logic rr);
    rst_n = 1'b0; req = '0; iter_done = 1'b0; prio = '0; preempt_en = '0; mode_rr = rr;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    expect_state("R1 reset", 1'b0, 0, '0);
  endtask

  task automatic t_fixed();
    do_reset(1'b0);
    set_prio(2, 5); set_prio(5, 9); set_prio(6, 9);
    pulse_req(bit_of(2) | bit_of(5) | bit_of(6));
    expect_state("R2 tie lowest index", 1'b1, 5, bit_of(5));
    pulse_done();
    expect_state("R5 release", 1'b0, 0, '0);
    step();
    expect_state("R4 pending kept", 1'b1, 6, bit_of(6));
    pulse_done(); step();
    expect_state("R2 lowest prio last", 1'b1, 2, bit_of(2));
    pulse_done();
    expect_state("R5 release end", 1'b0, 0, '0);
  endtask

  task automatic t_rearm();
    do_reset(1'b0);
    pulse_req(bit_of(3));
    expect_state("R4 grant", 1'b1, 3, bit_of(3));
    iter_done = 1'b1; req = bit_of(3); step(); iter_done = 1'b0; req = '0;
    expect_state("R4 done idle", 1'b0, 0, '0);
    step();
    expect_state("R4 rearmed", 1'b1, 3, bit_of(3));
    pulse_done(); step();
    expect_state("R4 consumed", 1'b0, 0, '0);
  endtask

  task automatic t_rr();
    do_reset(1'b1);
    set_prio(5, 15); set_prio(0, 1);
    pulse_req(bit_of(0) | bit_of(3) | bit_of(5));
    expect_state("R3 start at 0", 1'b1, 0, bit_of(0));
    pulse_done(); step();
    expect_state("R3 next 3", 1'b1, 3, bit_of(3));
    pulse_done(); step();
    expect_state("R3 next 5", 1'b1, 5, bit_of(5));
    pulse_done();
    pulse_req(bit_of(1) | bit_of(6));
    expect_state("R3 after 5 is 6", 1'b1, 6, bit_of(6));
    pulse_done(); step();
    expect_state("R3 wrap to 1", 1'b1, 1, bit_of(1));
    pulse_done();
    preempt_en = '1; set_prio(2, 1); set_prio(7, 15);
    pulse_req(bit_of(2));
    expect_state("R3 rr grant 2", 1'b1, 2, bit_of(2));
    pulse_req(bit_of(7));
    expect_state("R8 no rr preempt", 1'b1, 2, bit_of(2));
    step();
    expect_state("R8 still held", 1'b1, 2, bit_of(2));
    pulse_done(); step();
    expect_state("R8 then 7", 1'b1, 7, bit_of(7));
    pulse_done();
  endtask

  task automatic t_preempt();
    do_reset(1'b0);
    preempt_en[1] = 1'b1;
    set_prio(1, 3); set_prio(4, 7); set_prio(6, 15);
    pulse_req(bit_of(1));
    expect_state("R2 grant 1", 1'b1, 1, bit_of(1));
    pulse_req(bit_of(4));
    expect_state("R6 preempt by 4", 1'b1, 4, bit_of(1) | bit_of(4));
    pulse_req(bit_of(6));
    expect_state("R9 no nesting", 1'b1, 4, bit_of(1) | bit_of(4));
    step();
    expect_state("R12 two active", 1'b1, 4, bit_of(1) | bit_of(4));
    pulse_done();
    expect_state("R10 resume 1", 1'b1, 1, bit_of(1));
    step();
    expect_state("R6 preempt by 6", 1'b1, 6, bit_of(1) | bit_of(6));
    pulse_done();
    expect_state("R10 resume again", 1'b1, 1, bit_of(1));
    pulse_done();
    expect_state("R5 all done", 1'b0, 0, '0);
  endtask

  task automatic t_no_preempt();
    do_reset(1'b0);
    set_prio(2, 2); set_prio(3, 9);
    pulse_req(bit_of(2));
    expect_state("R7 grant 2", 1'b1, 2, bit_of(2));
    pulse_req(bit_of(3));
    expect_state("R7 enable off", 1'b1, 2, bit_of(2));
    pulse_done(); step();
    expect_state("R7 3 after", 1'b1, 3, bit_of(3));
    pulse_done();
    preempt_en[5] = 1'b1; set_prio(5, 6); set_prio(0, 6);
    pulse_req(bit_of(5));
    expect_state("R7 grant 5", 1'b1, 5, bit_of(5));
    pulse_req(bit_of(0));
    expect_state("R7 equal prio", 1'b1, 5, bit_of(5));
    pulse_done(); step();
    expect_state("R7 0 after", 1'b1, 0, bit_of(0));
    pulse_done();
  endtask

  task automatic t_idle_done();
    do_reset(1'b0);
    pulse_done();
    expect_state("R11 idle done", 1'b0, 0, '0);
    pulse_req(bit_of(4));
    expect_state("R11 later grant", 1'b1, 4, bit_of(4));
    pulse_done();
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_rearm();
    t_rr();
    t_preempt();
    t_no_preempt();
    t_idle_done();
    finish_run();
  end
endmodule